// File: doc/BRIEF.md
# Serial LUT-Memory Configuration Loader

This block writes a configuration bitstream into a row of tiles. The routing multiplexers and lookup tables of each tile are small writable memories. Each tile holds `DATA_W` memories with `2^ADDR_W` entries each. A start pulse launches a load. One address counter is shared by all tiles and walks every entry. A single one-hot write-enable token sits in a chain of flip-flops, one flip-flop per tile, and marks the tile being written.

Bitstream words arrive one per cycle, each qualified by a valid strobe. Bit `i` of an accepted word goes to memory `i` of the tile that holds the token, at the current counter address. When the counter wraps, the token moves to the next tile. When the token leaves the last tile, the load is complete and a done flag rises.

The interface is deliberately thin. The block does not buffer the bitstream and does not source it. Only the tile-side write strobes, the shared address and the data bus leave the block.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset, every tile write enable is 0, the address is 0 and done is 0.
- R2: A start pulse while no load is running places the token in tile 0 and clears the address to 0 and done to 0 at the next edge. The first accepted word is then written to tile 0, address 0.
- R3: `tile_we_o[t]` is high exactly in cycles where tile `t` holds the token and `bs_valid_i` is high. At most one enable is high in any cycle.
- R4: `cfg_data_o` carries `bs_data_i` in the same cycle, so bit `i` feeds memory `i`.
- R5: The address advances by one only on cycles with `bs_valid_i` high during a load. It holds during stalls and wraps from `2^ADDR_W-1` to 0.
- R6: A valid word accepted at the last address moves the token from tile `t` to tile `t+1`.
- R7: A valid word accepted at the last address of the last tile clears the token and raises done at the next edge. Done then stays high until the next accepted start.
- R8: A start pulse during a load, including one in the cycle of the final word, has no effect on the token or the address.
- R9: A full load takes exactly `NUM_TILES * 2^ADDR_W` valid words. Done is still 0 after one word fewer.
- R10: Valid words outside a load produce no write enable and leave the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load start pulse |
| bs_data_i | input | DATA_W | Bitstream word, one bit per tile memory |
| bs_valid_i | input | 1 | Bitstream word valid |
| tile_we_o | output | NUM_TILES | Per-tile write enables, one-hot or zero |
| cfg_addr_o | output | ADDR_W | Shared memory write address |
| cfg_data_o | output | DATA_W | Data bus to the memories of every tile |
| done_o | output | 1 | Load complete, held until the next start |

## Verification
Two functions can fall in one cycle: a start request and a word that is being accepted.

The bench provokes this in several ways:
- It raises start alongside valid words in the middle of a load.
- It raises start in the very cycle that carries the final word of the last tile.
- It raises start together with valid data while the loader is idle.

A scoreboard judges every write enable, address and data word against a model built from the requirements. After each drive it also compares the address, the done flag and the absence of enables outside a load.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the configuration loader.
// Assumes: nothing beyond a synthesizable SystemVerilog target.
package cfg_loader_pkg;

    // Load phase of the loader
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_DONE = 2'd2
    } load_phase_e;

endpackage

// File: rtl/cfg_addr_counter.sv
// Shared write-address counter for every memory of the active tile.
// Clears on launch and steps on each accepted word. It wraps naturally
// at 2^ADDR_W, and wrap_o flags the last entry.
// Assumes: launch_i and step_i are never high together.
module cfg_addr_counter #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    // Address register: clear on launch, increment on accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (launch_i) begin
            addr_q <= '0;
        end else if (step_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Last-entry flag for the token chain
    always_comb begin
        wrap_o = (addr_q == LAST_ADDR);
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/cfg_token_chain.sv
// Shift chain of per-tile write-enable flip-flops holding a one-hot token.
// Launch loads the token into tile 0. An advance moves it one tile on, and
// out of the last tile it leaves the chain empty, which raises exit_o.
// Assumes: launch_i and advance_i are never high together.
module cfg_token_chain #(
    parameter int NUM_TILES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_i,
    input  logic                 advance_i,
    output logic [NUM_TILES-1:0] token_o,
    output logic                 exit_o
);

    localparam int LAST = NUM_TILES - 1;

    logic [NUM_TILES-1:0] tok_q;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_stage
        if (t == 0) begin : g_head
            // Head stage: set on launch, emptied on advance
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tok_q[t] <= 1'b0;
                end else if (launch_i) begin
                    tok_q[t] <= 1'b1;
                end else if (advance_i) begin
                    tok_q[t] <= 1'b0;
                end
            end
        end else begin : g_body
            // Body stage: cleared on launch, takes the previous stage on advance
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tok_q[t] <= 1'b0;
                end else if (launch_i) begin
                    tok_q[t] <= 1'b0;
                end else if (advance_i) begin
                    tok_q[t] <= tok_q[t-1];
                end
            end
        end
    end

    // Token leaves the chain when the last stage is advanced
    always_comb begin
        exit_o = advance_i & tok_q[LAST];
    end

    assign token_o = tok_q;

endmodule

// File: rtl/cfg_phase_ctrl.sv
// Load phase controller: idle, loading and done.
// Accepts a start only outside a load, and reports done until the next start.
// Assumes: exit_i is high only while loading.
module cfg_phase_ctrl
    import cfg_loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic exit_i,
    output logic launch_o,
    output logic loading_o,
    output logic done_o
);

    load_phase_e phase_q;
    load_phase_e phase_d;

    // Start is honoured only when no load is running
    always_comb begin
        launch_o  = start_i && (phase_q != PH_LOAD);
        loading_o = (phase_q == PH_LOAD);
        done_o    = (phase_q == PH_DONE);
    end

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (start_i) phase_d = PH_LOAD;
            PH_LOAD: if (exit_i)  phase_d = PH_DONE;
            PH_DONE: if (start_i) phase_d = PH_LOAD;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/cfg_chain_loader.sv
// Top of the serial configuration loader.
// Gates the one-hot tile token with the word-valid strobe to form the tile
// write enables, and routes the word straight onto the shared data bus.
// Assumes: the tile memories write synchronously on the edge that ends
// a cycle in which their enable is high.
module cfg_chain_loader #(
    parameter int NUM_TILES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_W-1:0]    bs_data_i,
    input  logic                 bs_valid_i,
    output logic [NUM_TILES-1:0] tile_we_o,
    output logic [ADDR_W-1:0]    cfg_addr_o,
    output logic [DATA_W-1:0]    cfg_data_o,
    output logic                 done_o
);

    logic                 launch;
    logic                 loading;
    logic                 step;
    logic                 wrap;
    logic                 advance;
    logic                 tok_exit;
    logic [NUM_TILES-1:0] tok_q;

    cfg_phase_ctrl u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .exit_i    (tok_exit),
        .launch_o  (launch),
        .loading_o (loading),
        .done_o    (done_o)
    );

    cfg_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .step_i   (step),
        .addr_o   (cfg_addr_o),
        .wrap_o   (wrap)
    );

    cfg_token_chain #(.NUM_TILES(NUM_TILES)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .advance_i (advance),
        .token_o   (tok_q),
        .exit_o    (tok_exit)
    );

    // Word acceptance and token advance conditions
    always_comb begin
        step    = bs_valid_i & loading;
        advance = step & wrap;
    end

    // Tile write enables and data bus
    always_comb begin
        tile_we_o  = tok_q & {NUM_TILES{bs_valid_i}};
        cfg_data_o = bs_data_i;
    end

endmodule

// File: rtl/cfg_chain_loader_chk.sv
// Property checker for the configuration loader, attached by bind.
// Assumes: it observes the top ports and the internal token register.
module cfg_chain_loader_chk #(
    parameter int NUM_TILES = 4,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 bs_valid_i,
    input logic [NUM_TILES-1:0] tile_we_o,
    input logic [ADDR_W-1:0]    cfg_addr_o,
    input logic                 done_o,
    input logic [NUM_TILES-1:0] tok_q
);

    // R3
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tile_we_o));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && tok_q == '0) |=> (tok_q == NUM_TILES'(1) && cfg_addr_o == '0 && !done_o));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_valid_i && !start_i) |=> $stable(cfg_addr_o));

    // R6
    token_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_valid_i && tok_q != '0 && !tok_q[NUM_TILES-1] && cfg_addr_o == '1)
            |=> (tok_q == ($past(tok_q) << 1)));

    // R7
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_valid_i && tok_q[NUM_TILES-1] && cfg_addr_o == '1) |=> (done_o && tok_q == '0));

    // R7
    done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && tok_q != '0 && !bs_valid_i) |=> ($stable(tok_q) && $stable(cfg_addr_o)));

endmodule

bind cfg_chain_loader cfg_chain_loader_chk #(
    .NUM_TILES (NUM_TILES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bs_valid_i (bs_valid_i),
    .tile_we_o  (tile_we_o),
    .cfg_addr_o (cfg_addr_o),
    .done_o     (done_o),
    .tok_q      (tok_q)
);

// File: tb/cfg_chain_loader_tb.sv
module cfg_chain_loader_tb;

    localparam int TILES = 3;
    localparam int AW    = 2;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        int           tile;
        int           addr;
        logic [DW-1:0] data;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DW-1:0]    bs_data_i = '0;
    logic             bs_valid_i = 1'b0;
    logic [TILES-1:0] tile_we_o;
    logic [AW-1:0]    cfg_addr_o;
    logic [DW-1:0]    cfg_data_o;
    logic             done_o;

    int    checks = 0;
    int    errors = 0;
    item_t exp_q[$];

    // Reference model state
    bit m_loading = 0;
    bit m_done    = 0;
    int m_tile    = 0;
    int m_addr    = 0;
    int accepted  = 0;

    always #2.5 clk = ~clk;

    cfg_chain_loader #(.NUM_TILES(TILES), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bs_data_i  (bs_data_i),
        .bs_valid_i (bs_valid_i),
        .tile_we_o  (tile_we_o),
        .cfg_addr_o (cfg_addr_o),
        .cfg_data_o (cfg_data_o),
        .done_o     (done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, pushes expected writes, checks state
    task automatic drive(input bit s, input bit v, input logic [DW-1:0] d);
        bit pre_loading;
        bit pre_done;
        int pre_addr;
        @(negedge clk);
        start_i    = s;
        bs_valid_i = v;
        bs_data_i  = d;
        pre_loading = m_loading;
        pre_done    = m_done;
        pre_addr    = m_addr;
        if (m_loading && v) exp_q.push_back('{m_tile, m_addr, d});
        #2;
        check("R7 done level", int'(done_o), int'(pre_done));
        if (pre_loading) check("R5 address", int'(cfg_addr_o), pre_addr);
        else begin
            check("R10 no write outside load", int'(tile_we_o), 0);
            check("R10 address idle", int'(cfg_addr_o), pre_addr);
        end
        // model update for the coming edge
        if (m_loading && v) begin
            accepted++;
            if (m_addr == DEPTH - 1) begin
                m_addr = 0;
                if (m_tile == TILES - 1) begin
                    m_loading = 0;
                    m_done    = 1;
                end else m_tile++;
            end else m_addr++;
        end else if (!m_loading && s) begin
            m_loading = 1;
            m_done    = 0;
            m_tile    = 0;
            m_addr    = 0;
            accepted  = 0;
        end
    endtask

    // Monitor: pops expected writes and compares them with the tile bus
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && tile_we_o != '0) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected write", int'(tile_we_o), 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check("R3 R6 tile enable", int'(tile_we_o), 1 << it.tile);
                    check("R5 write address", int'(cfg_addr_o), it.addr);
                    check("R4 data bus", int'(cfg_data_o), int'(it.data));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check("R1 enables", int'(tile_we_o), 0);
        check("R1 address", int'(cfg_addr_o), 0);
        check("R1 done", int'(done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 valid words while idle
        drive(0, 1, 8'hA5);
        drive(0, 1, 8'h5A);

        // R2 start together with valid data while idle
        drive(1, 1, 8'hFF);
        drive(0, 1, 8'h11);
        check("R2 first write to tile 0", int'(tile_we_o), 1);
        check("R2 first address", int'(cfg_addr_o), 0);

        // First load with stalls and R8 starts mid-load
        for (int i = 1; i < TILES * DEPTH; i++) begin
            if (i % 3 == 0) drive(1, 0, 8'h00);
            if (i % 4 == 1) drive(0, 0, 8'h00);
            drive((i % 5 == 2) || (i == TILES * DEPTH - 1), 1, 8'(i * 37 + 3));
        end
        drive(0, 0, 8'h00);
        check("R7 done after load", int'(done_o), 1);
        check("R8 start on final word ignored", int'(cfg_addr_o), 0);
        drive(0, 1, 8'h77);
        drive(0, 0, 8'h00);
        check("R7 done held", int'(done_o), 1);

        // Second load, back to back, R9 length
        drive(1, 0, 8'h00);
        for (int i = 0; i < TILES * DEPTH; i++) begin
            drive(0, 1, 8'(i ^ 8'h3C));
            if (i == TILES * DEPTH - 2) begin
                #1;
                check("R9 not done one word early", int'(done_o), 0);
            end
        end
        drive(0, 0, 8'h00);
        check("R9 word count", accepted, TILES * DEPTH);
        check("R9 done after full load", int'(done_o), 1);
        repeat (2) drive(0, 0, 8'h00);
        check("R3 all writes seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule